// File: doc/BRIEF.md
# Clause 45 MDIO Management Master

This block is a register-mapped station-management master for Clause 45 devices. Software first places a 16-bit register number in the address register. It then writes the management register with the port address, device address, a 3-bit operation code and, for writes, 16 data bits. That write launches a two-frame sequence on the management pins. The first frame is an address frame that carries the register number. The second frame is either a write frame or a read frame, and it follows with no idle gap. Software polls the busy bit until it clears. For a read, it then takes the data once read-valid is set.

The sequencer has three states. `S_IDLE` moves to `S_ADDR` when a launch is accepted. `S_ADDR` moves to `S_DATA` at the end of the address frame. `S_DATA` returns to `S_IDLE` at the end of the second frame. Busy is high in every state other than `S_IDLE`.

Each frame is 64 MDC periods long, with the fields sent most significant bit first:

| Bits | Field |
|------|-------|
| 0–31 | preamble of ones |
| 32–33 | start, `00` |
| 34–35 | opcode |
| 36–40 | port address |
| 41–45 | device address |
| 46–47 | turnaround |
| 48–63 | data |

The MDC period is one of four divide ratios of the system clock. It is chosen in a configuration register. The ratio is captured when an access launches, so a new setting takes hold at the next access.

Top module: `mdio45_master`

## Requirements
- R1: After reset, every register reads 0, MDC is low and the MDIO output enable is low.
- R2: The address register at offset 0x8 keeps bits 15:0 of a write and reads them back with zeros above. The configuration register at offset 0xC keeps and returns all 32 written bits. Any unmapped offset (for example 0x4) reads 0.
- R3: The management register is at offset 0x0. Its fields are data 15:0, port address 20:16, device address 25:21, operation 28:26, read-valid 29 and busy 30. A write to it while idle whose operation is 5 (write) or 7 (read) sets busy on the next cycle. Any other operation value starts no MDC activity and leaves the register reading unchanged.
- R4: The first frame of each access is the address frame. It is 32 ones, start `00`, opcode `00`, the port address, the device address, turnaround `10` and the address register contents, with the output enable high for all 64 bits.
- R5: For operation 5 the second frame follows at once. It has opcode `01`, turnaround `10` and the written data, driven for all 64 bits.
- R6: For operation 7 the second frame has opcode `11`. The output enable drops from bit 46 (the first turnaround bit) to the end of the frame. The 16 bits sampled on the MDC rising edges of bits 48..63 appear in data 15:0, most significant bit first.
- R7: Read-valid (bit 29) is cleared when an access launches. At the end of a read frame it is set exactly when MDIO was sampled low during the second turnaround bit (bit 47).
- R8: Configuration bits 1:0 set the MDC period N in system clocks: 0 gives 256, 1 gives 64, 2 gives 32, 3 gives 8. MDC is high for the second half of each period and low whenever the block is idle.
- R9: The two frames are contiguous, so busy stays set for exactly 128·N cycles from the launch edge.
- R10: A management register write while busy is ignored. The frames in flight, the readback fields and the MDC activity after the access are unchanged by it.
- R11: A configuration write while busy changes the readback at once, but the MDC period of the running access stays unchanged. The new ratio applies from the next launch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data out |
| mdio_oe | output | 1 | Output enable for the bidirectional MDIO pad |
| mdio_i | input | 1 | Serial data in from the pad |

## Verification
Busy reads high from the first falling system-clock edge after the launching write. The bench counts falling edges with busy high and requires exactly 128·N of them. The model device samples `mdio_o` and `mdio_oe` on each MDC rising edge. It drives `mdio_i` just after MDC falls, which is the same system edge where the design advances its bit index, so each response bit is stable for N/2 cycles before the design samples it. Read data and read-valid update on the edge where busy drops. The bench therefore reads them at the first falling edge on which busy is seen low, and it checks MDC period and frame content only after the access has ended.

// File: rtl/mdio45_pkg.sv
package mdio45_pkg;

    localparam int REG_AW = 4;

    // Register offsets
    localparam logic [REG_AW-1:0] OFS_MGMT = 4'h0;
    localparam logic [REG_AW-1:0] OFS_ADDR = 4'h8;
    localparam logic [REG_AW-1:0] OFS_CFG  = 4'hC;

    // Operation codes in the management register
    localparam logic [2:0] OPC_WRITE = 3'd5;
    localparam logic [2:0] OPC_READ  = 3'd7;

    // Management register field positions
    localparam int F_PORT_LO = 16;
    localparam int F_DEV_LO  = 21;
    localparam int F_OP_LO   = 26;
    localparam int F_RVALID  = 29;
    localparam int F_BUSY    = 30;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ADDR,
        S_DATA
    } seq_state_t;

    // Half of the MDC period, in system clocks, for each divider encoding
    function automatic int half_period(input logic [1:0] sel);
        int h;
        unique case (sel)
            2'd0:    h = 128;
            2'd1:    h = 32;
            2'd2:    h = 16;
            default: h = 4;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/mdio45_clkgen.sv
module mdio45_clkgen
    import mdio45_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] sel,
    output logic       mdc,
    output logic       bit_end,
    output logic       rise_tick
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] half_m1;
    logic [CNT_W-1:0] last;

    always_comb begin
        half_m1   = CNT_W'(half_period(sel) - 1);
        last      = CNT_W'(2 * half_period(sel) - 1);
        bit_end   = run && (cnt_q == last);
        rise_tick = run && (cnt_q == half_m1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else begin
            if (!run || bit_end) cnt_q <= '0;
            else                 cnt_q <= cnt_q + 1'b1;

            if (!run || bit_end) mdc <= 1'b0;
            else if (rise_tick)  mdc <= 1'b1;
        end
    end

endmodule

// File: rtl/mdio45_shifter.sv
module mdio45_shifter #(
    parameter int FRAME_LEN = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [FRAME_LEN-1:0] frame,
    input  logic                 rd_frame,
    input  logic                 bit_end,
    input  logic                 rise_tick,
    input  logic                 mdio_i,
    output logic                 mdio_o,
    output logic                 mdio_oe,
    output logic                 frame_end,
    output logic [15:0]          rx_data,
    output logic                 ta_low
);

    localparam int IDX_W    = $clog2(FRAME_LEN);
    localparam int TA_POS   = FRAME_LEN - 18;
    localparam int DATA_POS = FRAME_LEN - 16;

    logic [FRAME_LEN-1:0] sreg_q;
    logic [IDX_W-1:0]     idx_q;
    logic                 rd_q;

    assign mdio_o    = sreg_q[FRAME_LEN-1];
    assign frame_end = bit_end && (idx_q == IDX_W'(FRAME_LEN - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q  <= '1;
            idx_q   <= '0;
            rd_q    <= 1'b0;
            mdio_oe <= 1'b0;
            rx_data <= '0;
            ta_low  <= 1'b0;
        end else begin
            if (load) begin
                sreg_q  <= frame;
                idx_q   <= '0;
                rd_q    <= rd_frame;
                mdio_oe <= 1'b1;
                ta_low  <= 1'b0;
            end else if (bit_end) begin
                sreg_q <= {sreg_q[FRAME_LEN-2:0], 1'b1};
                idx_q  <= idx_q + 1'b1;
                if (frame_end)
                    mdio_oe <= 1'b0;
                else if (rd_q && idx_q == IDX_W'(TA_POS - 1))
                    mdio_oe <= 1'b0;
            end

            if (rise_tick && rd_q && !load) begin
                if (idx_q == IDX_W'(TA_POS + 1))
                    ta_low <= !mdio_i;
                if (idx_q >= IDX_W'(DATA_POS))
                    rx_data <= {rx_data[14:0], mdio_i};
            end
        end
    end

endmodule

// File: rtl/mdio45_master.sv
module mdio45_master
    import mdio45_pkg::*;
#(
    parameter int PRE_LEN = 32,
    parameter int CNT_W   = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);

    localparam int FRAME_LEN = PRE_LEN + 32;

    seq_state_t state_q, state_d;

    logic [4:0]  port_q, dev_q;
    logic [2:0]  op_q;
    logic [15:0] data_q, addr_q;
    logic [31:0] cfg_q;
    logic [1:0]  ratio_q;
    logic        rvalid_q;

    logic                 busy, wr_mgmt, op_ok, launch;
    logic                 bit_end, rise_tick, frame_end, ta_low;
    logic                 shift_load, rd_frame;
    logic [15:0]          rx_data;
    logic [FRAME_LEN-1:0] shift_frame;

    assign busy    = (state_q != S_IDLE);
    assign wr_mgmt = reg_we && (reg_addr == OFS_MGMT);
    assign op_ok   = (reg_wdata[F_OP_LO+2:F_OP_LO] == OPC_WRITE) ||
                     (reg_wdata[F_OP_LO+2:F_OP_LO] == OPC_READ);
    assign launch  = wr_mgmt && op_ok && !busy;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (launch)    state_d = S_ADDR;
            S_ADDR:  if (frame_end) state_d = S_DATA;
            S_DATA:  if (frame_end) state_d = S_IDLE;
            default:                state_d = S_IDLE;
        endcase
    end

    // Frame selection: the address frame takes its fields straight from the launching write
    always_comb begin
        shift_load = launch || (state_q == S_ADDR && frame_end);
        rd_frame   = !launch && (op_q == OPC_READ);
        if (launch)
            shift_frame = {{PRE_LEN{1'b1}}, 2'b00, 2'b00,
                           reg_wdata[F_PORT_LO+4:F_PORT_LO],
                           reg_wdata[F_DEV_LO+4:F_DEV_LO], 2'b10, addr_q};
        else
            shift_frame = {{PRE_LEN{1'b1}}, 2'b00,
                           (op_q == OPC_READ) ? 2'b11 : 2'b01,
                           port_q, dev_q, 2'b10, data_q};
    end

    // Register file and results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_q   <= '0;
            dev_q    <= '0;
            op_q     <= '0;
            data_q   <= '0;
            addr_q   <= '0;
            cfg_q    <= '0;
            ratio_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            if (launch) begin
                data_q   <= reg_wdata[15:0];
                port_q   <= reg_wdata[F_PORT_LO+4:F_PORT_LO];
                dev_q    <= reg_wdata[F_DEV_LO+4:F_DEV_LO];
                op_q     <= reg_wdata[F_OP_LO+2:F_OP_LO];
                ratio_q  <= cfg_q[1:0];
                rvalid_q <= 1'b0;
            end else if (state_q == S_DATA && frame_end && op_q == OPC_READ) begin
                data_q   <= rx_data;
                rvalid_q <= ta_low;
            end
            if (reg_we && reg_addr == OFS_ADDR) addr_q <= reg_wdata[15:0];
            if (reg_we && reg_addr == OFS_CFG)  cfg_q  <= reg_wdata;
        end
    end

    // Read mux
    always_comb begin
        unique case (reg_addr)
            OFS_MGMT: reg_rdata = {1'b0, busy, rvalid_q, op_q, dev_q, port_q, data_q};
            OFS_ADDR: reg_rdata = {16'd0, addr_q};
            OFS_CFG:  reg_rdata = cfg_q;
            default:  reg_rdata = '0;
        endcase
    end

    mdio45_clkgen #(.CNT_W(CNT_W)) u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .sel       (ratio_q),
        .mdc       (mdc),
        .bit_end   (bit_end),
        .rise_tick (rise_tick)
    );

    mdio45_shifter #(.FRAME_LEN(FRAME_LEN)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (shift_load),
        .frame     (shift_frame),
        .rd_frame  (rd_frame),
        .bit_end   (bit_end),
        .rise_tick (rise_tick),
        .mdio_i    (mdio_i),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .frame_end (frame_end),
        .rx_data   (rx_data),
        .ta_low    (ta_low)
    );

    p_launch_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> busy);

    p_addr_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ADDR) |-> mdio_oe);

    p_rvalid_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> !rvalid_q);

    p_idle_mdc_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    p_ignore_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_mgmt) |=> ($stable(port_q) && $stable(dev_q) && $stable(op_q)));

    p_ratio_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(ratio_q));

endmodule

// File: tb/sim_mdio45_master.sv
module sim_mdio45_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    always #4 clk = ~clk;

    mdio45_master u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;

    always @(negedge clk) cyc++;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Model management device
    int          pc = 0;
    int          last_rise = 0;
    int          exp_n = 8;
    int          per_err = 0;
    logic        ta_drive_low = 1'b1;
    logic [15:0] resp = 16'h0;
    logic [63:0] cap_o = '0, cap_oe = '0;
    logic [63:0] fo[2];
    logic [63:0] foe[2];

    always @(posedge mdc) begin
        int b;
        b = pc % 64;
        cap_o[63-b]  = mdio_o;
        cap_oe[63-b] = mdio_oe;
        if ((pc % 128) != 0 && (cyc - last_rise) != exp_n) per_err++;
        last_rise = cyc;
        if (b == 63) begin
            fo[(pc/64)%2]  = cap_o;
            foe[(pc/64)%2] = cap_oe;
        end
        pc++;
    end

    always @(negedge mdc) begin
        int nb;
        nb = pc % 64;
        if (cap_o[63-34] && cap_o[63-35] && nb >= 46) begin
            if (nb == 46)      mdio_i = 1'b1;
            else if (nb == 47) mdio_i = ta_drive_low ? 1'b0 : 1'b1;
            else               mdio_i = resp[63-nb];
        end else begin
            mdio_i = 1'b1;
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_idle(output int n);
        reg_addr = 4'h0;
        n = 0;
        #1;
        while (reg_rdata[30]) begin
            n++;
            @(negedge clk);
            #1;
        end
    endtask

    function automatic int ratio(input logic [1:0] sel);
        return (sel == 2'd0) ? 256 : (sel == 2'd1) ? 64 : (sel == 2'd2) ? 32 : 8;
    endfunction

    task automatic check_frames(input logic rdop, input logic [4:0] port, input logic [4:0] dev,
                                input logic [15:0] ra, input logic [15:0] wd,
                                input logic tal, input logic [15:0] rsp);
        logic [63:0] m;
        logic [31:0] v;
        // R4 address frame
        chk("R4", fo[0], {32'hFFFF_FFFF, 4'b0000, port, dev, 2'b10, ra});
        chk("R4", foe[0], 64'hFFFF_FFFF_FFFF_FFFF);
        if (!rdop) begin
            chk("R5", fo[1], {32'hFFFF_FFFF, 4'b0001, port, dev, 2'b10, wd});
            chk("R5", foe[1], 64'hFFFF_FFFF_FFFF_FFFF);
        end else begin
            m = {{46{1'b1}}, 18'd0};
            chk("R6", fo[1] & m, {32'hFFFF_FFFF, 4'b0011, port, dev, 18'd0});
            chk("R6", foe[1], m);
            rd(4'h0, v);
            chk("R7", {63'd0, v[29]}, {63'd0, tal});
            if (tal) chk("R6", {48'd0, v[15:0]}, {48'd0, rsp});
        end
    endtask

    task automatic access(input logic setcfg, input logic rdop, input logic [4:0] port,
                          input logic [4:0] dev, input logic [15:0] ra, input logic [15:0] wd,
                          input logic [1:0] sel, input logic tal, input logic [15:0] rsp);
        int n;
        if (setcfg) wr(4'hC, {30'd0, sel});
        wr(4'h8, {16'd0, ra});
        exp_n = ratio(sel); per_err = 0; ta_drive_low = tal; resp = rsp;
        wr(4'h0, {1'b0, 2'b00, rdop ? 3'd7 : 3'd5, dev, port, wd});
        wait_idle(n);
        chk("R9", 64'(n), 64'(128 * ratio(sel)));
        chk("R8", 64'(per_err), 64'd0);
        check_frames(rdop, port, dev, ra, wd, tal, rsp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL R9: watchdog expired, got hang expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int n, pc0;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(4'h0, v); chk("R1", 64'(v), 64'd0);
        rd(4'h8, v); chk("R1", 64'(v), 64'd0);
        rd(4'hC, v); chk("R1", 64'(v), 64'd0);
        chk("R1", {63'd0, mdc}, 64'd0);
        chk("R1", {63'd0, mdio_oe}, 64'd0);

        // R2 register map
        wr(4'h8, 32'h0001_ABCD); rd(4'h8, v); chk("R2", 64'(v), 64'h0000_ABCD);
        wr(4'hC, 32'hDEAD_BEE3); rd(4'hC, v); chk("R2", 64'(v), 64'hDEAD_BEE3);
        rd(4'h4, v); chk("R2", 64'(v), 64'd0);

        // R3 launches only on operation 5 or 7
        wr(4'h0, {3'b000, 3'd0, 5'd3, 5'd9, 16'h1234});
        rd(4'h0, v); chk("R3", 64'(v), 64'd0);
        wr(4'h0, {3'b000, 3'd6, 5'd3, 5'd9, 16'h1234});
        repeat (40) @(negedge clk);
        rd(4'h0, v); chk("R3", 64'(v), 64'd0);
        chk("R3", 64'(pc), 64'd0);

        // Sweep at divide-by-8: writes, reads, field extremes, both turnaround outcomes
        for (int i = 0; i < 6; i++) begin
            access(1'b1, i[0], 5'(31 - i * 5), 5'(i * 6 + 1),
                   16'hA5C3 ^ 16'(i * 16'h1111), 16'h5A0F + 16'(i * 16'h0F37),
                   2'd3, (i != 3), 16'hC001 ^ 16'(i << 8));
        end
        access(1'b1, 1'b0, 5'd0, 5'd31, 16'hFFFF, 16'h0000, 2'd3, 1'b1, 16'h0);
        access(1'b1, 1'b1, 5'd31, 5'd0, 16'h0000, 16'h0, 2'd3, 1'b1, 16'hFFFF);
        access(1'b1, 1'b1, 5'd17, 5'd2, 16'h8001, 16'h0, 2'd3, 1'b0, 16'h7FFE);

        // R8 other divide ratios
        access(1'b1, 1'b0, 5'd5, 5'd6, 16'h0102, 16'hBEEF, 2'd2, 1'b1, 16'h0);
        access(1'b1, 1'b1, 5'd7, 5'd8, 16'h0304, 16'h0, 2'd1, 1'b1, 16'h3C5A);
        access(1'b1, 1'b0, 5'd9, 5'd10, 16'h0506, 16'hCAFE, 2'd0, 1'b1, 16'h0);

        // R10 management write while busy is ignored
        wr(4'hC, 32'd3);
        wr(4'h8, 32'h0000_1357);
        exp_n = 8; per_err = 0; ta_drive_low = 1'b1; resp = 16'h2468;
        wr(4'h0, {1'b0, 2'b00, 3'd7, 5'd4, 5'd3, 16'h0});
        repeat (100) @(negedge clk);
        wr(4'h0, {1'b0, 2'b00, 3'd5, 5'd10, 5'd9, 16'h1234});
        wait_idle(n);
        check_frames(1'b1, 5'd3, 5'd4, 16'h1357, 16'h0, 1'b1, 16'h2468);
        rd(4'h0, v); chk("R10", 64'(v[28:16]), 64'({3'd7, 5'd4, 5'd3}));
        pc0 = pc;
        repeat (300) @(negedge clk);
        chk("R10", 64'(pc), 64'(pc0));
        rd(4'h0, v); chk("R10", {63'd0, v[30]}, 64'd0);

        // R11 divider change while busy waits for the next access
        wr(4'h8, 32'h0000_0A0A);
        exp_n = 8; per_err = 0;
        wr(4'h0, {1'b0, 2'b00, 3'd5, 5'd12, 5'd11, 16'h9999});
        repeat (50) @(negedge clk);
        wr(4'hC, 32'd2);
        rd(4'hC, v); chk("R11", 64'(v), 64'd2);
        wait_idle(n);
        chk("R11", 64'(per_err), 64'd0);
        check_frames(1'b0, 5'd11, 5'd12, 16'h0A0A, 16'h9999, 1'b1, 16'h0);
        access(1'b0, 1'b0, 5'd1, 5'd2, 16'h4321, 16'h8765, 2'd2, 1'b1, 16'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule